// File: doc/BRIEF.md
# Masked Interrupt Status Register

This block is the interrupt control word of a DMA disk host. One 16-bit word carries eight sticky event flags in its low byte and eight mask bits in its high byte, with each mask bit sitting exactly eight positions above the flag it governs. Single-cycle event pulses from the DMA engine, the bus and the attached device set the flags. A single register write does two things at once: it clears every flag whose low-byte data bit is 1, and it loads the high byte as the new mask.

The block drives one interrupt line. That line is high while any flag is set whose mask bit is 0. A side input is pulsed when software clears the interrupt bit of the neighbouring DMA status register. That pulse clears the transfer-end and host flags and also wipes the whole mask byte, so software has to restore the mask afterwards. The usual start-up sequence writes a mask of 0xFA, which leaves only bus error and host unmasked, and writes 0xFF to the low byte to clear all flags.

Flag positions:

| Bit | Flag |
|-----|------|
| 7 | address error |
| 6 | reach-multiple |
| 5 | device timing error |
| 4 | UDMA terminate |
| 3 | timer |
| 2 | bus error |
| 1 | transfer end |
| 0 | host/device interrupt |

Top module: `irq_ctl_reg`

## Requirements
- R1: After reset, `rd_data` is 0x0000 and `irq_out` is 0. No flag is set and no mask bit is set.
- R2: An `evt_pulse[i]` high at a clock edge sets flag i, and the flag reads 1 in `rd_data[i]` after that edge.
- R3: A write with `wr_data[i]` = 1 (for i in 0..7) clears flag i. A write with `wr_data[i]` = 0 leaves flag i unchanged.
- R4: A write loads `wr_data[15:8]` into the mask byte, which reads back in `rd_data[15:8]`. The mask for flag i is bit i+8.
- R5: `irq_out` is 1 exactly when some flag i is set while mask bit i+8 is 0.
- R6: When an event pulse and a write-one-to-clear hit the same flag in the same cycle, the flag ends up set.
- R7: A `dma_irq_clr` pulse clears flag 1 (transfer end) and flag 0 (host). Flags 7..2 are left unchanged.
- R8: A `dma_irq_clr` pulse with no register write in the same cycle sets the mask byte to 0x00.
- R9: When `dma_irq_clr` and a register write coincide, the mask takes `wr_data[15:8]`. The flag clears from both sources apply together.
- R10: A flag with no event pulse and no clear in a cycle keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Write data: mask in [15:8], clear bits in [7:0] |
| evt_pulse | input | 8 | Event pulses, one per flag |
| dma_irq_clr | input | 1 | DMA status interrupt-clear pulse |
| rd_data | output | 16 | Current {mask, flags} |
| irq_out | output | 1 | Combined unmasked interrupt |

## Verification
All state in this block is visible on `rd_data`, so a wrong flag or mask bit shows there one cycle after the edge that produced it. `irq_out` then disagrees with the bench model in that same cycle. Random traffic drives events, writes and DMA clears together, including collisions on the same bit. Because of that, a wrong priority between set and clear, or between the DMA wipe and a write, appears within a few hundred cycles. A clear that reaches the wrong flag, or a DMA wipe that leaves stale mask bits, shows up in the first directed sequence.

// File: rtl/irq_ctl_pkg.sv
`timescale 1ns/1ps
package irq_ctl_pkg;
    localparam int EVT_COUNT   = 8;
    localparam int B_ADDR_ERR  = 7;
    localparam int B_REACH_MUL = 6;
    localparam int B_DEV_TIME  = 5;
    localparam int B_UDMA_TERM = 4;
    localparam int B_TIMER     = 3;
    localparam int B_BUS_ERR   = 2;
    localparam int B_XFER_END  = 1;
    localparam int B_HOST      = 0;
endpackage

// File: rtl/irq_flag_bit.sv
`timescale 1ns/1ps
// One sticky flag: the set input has priority over the clear input.
module irq_flag_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    logic q_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q_r <= 1'b0;
        else if (set_i)  q_r <= 1'b1;
        else if (clr_i)  q_r <= 1'b0;
    end

    assign q_o = q_r;

    // R2 and R6: a set always wins, even against a clear in the same cycle
    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o);
    // R3: a clear with no set leaves the flag at 0
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !q_o);
    // R10: with no set and no clear the flag holds its value
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> (q_o == $past(q_o)));
endmodule

// File: rtl/irq_mask_reg.sv
`timescale 1ns/1ps
module irq_mask_reg #(
    parameter int          W   = 8,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic         wipe_i,
    output logic [W-1:0] mask_o
);
    logic [W-1:0] mask_r;

    // R9: a register write in the same cycle takes priority over the wipe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mask_r <= RST;
        else if (wr_i)    mask_r <= wdata_i;
        else if (wipe_i)  mask_r <= '0;
    end

    assign mask_o = mask_r;

    // R4 and R9: after a write, the mask holds the written value
    p_wr_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (mask_o == $past(wdata_i)));
    // R8: a wipe with no write zeroes the mask
    p_wipe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wipe_i && !wr_i) |=> (mask_o == '0));
endmodule

// File: rtl/irq_combine.sv
`timescale 1ns/1ps
module irq_combine #(
    parameter int W = 8
) (
    input  logic [W-1:0] flags_i,
    input  logic [W-1:0] mask_i,
    output logic         irq_o
);
    logic [W-1:0] live;

    always_comb begin
        for (int i = 0; i < W; i++) live[i] = flags_i[i] & ~mask_i[i];
        irq_o = |live;
    end
endmodule

// File: rtl/irq_ctl_reg.sv
`timescale 1ns/1ps
module irq_ctl_reg
    import irq_ctl_pkg::*;
#(
    parameter int                 EV_N        = EVT_COUNT,
    parameter logic [EV_N-1:0]    MASK_RST    = '0,
    parameter logic [EV_N-1:0]    DMA_CLR_SEL = EV_N'((1 << B_XFER_END) | (1 << B_HOST))
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [2*EV_N-1:0]   wr_data,
    input  logic [EV_N-1:0]     evt_pulse,
    input  logic                dma_irq_clr,
    output logic [2*EV_N-1:0]   rd_data,
    output logic                irq_out
);
    localparam int REG_W = 2 * EV_N;

    logic [EV_N-1:0] flags;
    logic [EV_N-1:0] mask;
    logic [EV_N-1:0] clr_vec;

    // R3 and R7: write-one-to-clear from the low byte, plus the selected bits on a DMA clear
    always_comb begin
        clr_vec = '0;
        if (wr_en)       clr_vec = clr_vec | wr_data[EV_N-1:0];
        if (dma_irq_clr) clr_vec = clr_vec | DMA_CLR_SEL;
    end

    for (genvar i = 0; i < EV_N; i++) begin : g_flag
        irq_flag_bit u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (evt_pulse[i]),
            .clr_i (clr_vec[i]),
            .q_o   (flags[i])
        );
    end

    irq_mask_reg #(.W(EV_N), .RST(MASK_RST)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_en),
        .wdata_i (wr_data[REG_W-1:EV_N]),
        .wipe_i  (dma_irq_clr),
        .mask_o  (mask)
    );

    // R5: combined interrupt line
    irq_combine #(.W(EV_N)) u_comb (
        .flags_i (flags),
        .mask_i  (mask),
        .irq_o   (irq_out)
    );

    assign rd_data = {mask, flags};
endmodule

// File: tb/sim_irq_ctl_reg.sv
`timescale 1ns/1ps
module sim_irq_ctl_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [7:0]  evt_pulse = '0;
    logic        dma_irq_clr = 1'b0;
    logic [15:0] rd_data;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    logic [7:0] m_flag = '0;
    logic [7:0] m_mask = '0;

    localparam logic [7:0] DMA_SEL = 8'h03;

    always #5 clk = ~clk;

    irq_ctl_reg u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .evt_pulse(evt_pulse), .dma_irq_clr(dma_irq_clr),
        .rd_data(rd_data), .irq_out(irq_out)
    );

    // Reference model: next {mask, flags} built from the requirements
    function automatic logic [15:0] model_next(logic [7:0] f, logic [7:0] m,
        logic [7:0] ev, logic wr, logic [15:0] wd, logic dc);
        logic [7:0] clr;
        logic [7:0] nm;
        clr = (wr ? wd[7:0] : 8'h00) | (dc ? DMA_SEL : 8'h00);
        nm  = wr ? wd[15:8] : (dc ? 8'h00 : m);
        return {nm, ev | (f & ~clr)};
    endfunction

    function automatic logic model_irq(logic [7:0] f, logic [7:0] m);
        return |(f & ~m);
    endfunction

    task automatic check_now(string tag);
        checks++;
        if (rd_data !== {m_mask, m_flag}) begin
            errors++;
            $display("FAIL %s rd_data actual=%h expected=%h", tag, rd_data, {m_mask, m_flag});
        end
        checks++;
        if (irq_out !== model_irq(m_flag, m_mask)) begin
            errors++;
            $display("FAIL R5 (%s) irq_out actual=%b expected=%b", tag, irq_out,
                     model_irq(m_flag, m_mask));
        end
    endtask

    task automatic step(logic [7:0] ev, logic wr, logic [15:0] wd, logic dc, string tag);
        logic [15:0] nx;
        evt_pulse = ev; wr_en = wr; wr_data = wd; dma_irq_clr = dc;
        @(posedge clk);
        nx = model_next(m_flag, m_mask, ev, wr, wd, dc);
        m_mask = nx[15:8];
        m_flag = nx[7:0];
        @(negedge clk);
        evt_pulse = '0; wr_en = 1'b0; wr_data = '0; dma_irq_clr = 1'b0;
        check_now(tag);
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check_now("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_now("R1 after release");
        // R4/R3: start-up mask write and clear-all
        step(8'h00, 1'b1, 16'hFAFF, 1'b0, "R4 init mask");
        // R2/R5: bus error is unmasked
        step(8'h04, 1'b0, 16'h0000, 1'b0, "R2 bus error set");
        // R2: a masked event still latches
        step(8'h80, 1'b0, 16'h0000, 1'b0, "R2 masked addr err");
        // R3: clear bit 2 only, with the zero bits ignored
        step(8'h00, 1'b1, 16'hFA04, 1'b0, "R3 w1c bus error");
        // R10: idle hold
        step(8'h00, 1'b0, 16'h0000, 1'b0, "R10 hold");
        // R6: event and clear collide on host bit
        step(8'h01, 1'b1, 16'hFA01, 1'b0, "R6 set beats clear");
        // R7/R8: transfer end and host cleared, mask wiped
        step(8'h02, 1'b0, 16'h0000, 1'b0, "R2 xfer end set");
        step(8'h00, 1'b0, 16'h0000, 1'b1, "R7 R8 dma clear");
        // R9: write coincides with dma clear
        step(8'h0C, 1'b0, 16'h0000, 1'b0, "R2 timer bus");
        step(8'h00, 1'b1, 16'h1208, 1'b1, "R9 write with dma clear");
        // R6 against dma clear
        step(8'h01, 1'b0, 16'h0000, 1'b1, "R6 set beats dma clear");
        step(8'h00, 1'b1, 16'hFFFF, 1'b0, "R3 clear all");
        for (int k = 0; k < 400; k++) begin
            logic [7:0]  ev;
            logic        wr;
            logic [15:0] wd;
            logic        dc;
            ev = 8'($urandom & $urandom & $urandom);
            wr = (($urandom % 4) == 0);
            wd = 16'($urandom);
            dc = (($urandom % 8) == 0);
            step(ev, wr, wd, dc, "R2 R3 R4 R6 R7 R8 R9 R10 random");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule